// File: doc/BRIEF.md
# Endian-Configurable Byte-Lane Steering Unit

This unit connects a 32-bit core data path to a memory built from four 8-bit banks. The memory holds an ascending byte sequence: bank k always holds the byte whose address has low bits equal to k, so word 0 covers bytes 0 to 3 and word 1 covers bytes 4 to 7. The unit takes a transfer size (byte, halfword or word), the two low address bits and a byte-order mode. From these it produces one enable per bank. It places write data on the matching lanes and gathers read data down to the low end of the core bus.

In little-endian mode the least significant byte of an item goes to the lowest-numbered byte address. In big-endian mode the most significant byte goes there instead. Byte and halfword reads are widened to 32 bits by zero or sign extension, chosen by an input. An access that does not sit on its natural boundary raises a misalignment flag and is suppressed. The unit does not split such an access into several bus cycles. The logic is purely combinational.

Top module: `lane_steer`

## Requirements
- R1: A byte transfer (size code 0) enables exactly one bank, the bank whose index equals addr_lo, in either byte order.
- R2: An aligned halfword (size code 1, addr_lo bit 0 clear) enables banks addr_lo and addr_lo+1. A word (size code 2, addr_lo 0) enables all four banks.
- R3: A halfword with addr_lo bit 0 set, a word with addr_lo not 0, or the reserved size code 3 sets misaligned to 1 and drives bank_en to 0000.
- R4: With big_endian=0, write byte j of core_wdata (j=0 least significant) appears on lane addr_lo+j of mem_wdata. Lane k is bits 8k+7:8k.
- R5: With big_endian=1 and an N-byte transfer, write byte j of core_wdata appears on lane addr_lo+N-1-j.
- R6: With big_endian=0, byte j of core_rdata is taken from lane addr_lo+j of mem_rdata, for j below N.
- R7: With big_endian=1, byte j of core_rdata is taken from lane addr_lo+N-1-j of mem_rdata, for j below N.
- R8: With sign_ext=0, the bits of core_rdata above the transfer width are 0.
- R9: With sign_ext=1, the bits of core_rdata above the transfer width copy the top bit of the transferred item. A word read is unaffected by sign_ext.
- R10: Every lane of mem_wdata whose bank enable is 0 carries zero.
- R11: When misaligned is 1, both mem_wdata and core_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| big_endian | input | 1 | Byte order: 1 = big-endian, 0 = little-endian |
| xfer_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr_lo | input | 2 | Low byte-address bits of the transfer |
| sign_ext | input | 1 | 1 = sign-extend narrow reads, 0 = zero-extend |
| core_wdata | input | 32 | Write value from the core, right-justified |
| mem_rdata | input | 32 | Read data from the four banks, lane k = bank k |
| bank_en | output | 4 | One enable per bank |
| mem_wdata | output | 32 | Write data steered onto the bank lanes |
| core_rdata | output | 32 | Read value aligned and extended for the core |
| misaligned | output | 1 | Access is off its natural boundary or of reserved size |

## Verification
The bench uses distinct byte values, so any lane swap shows up as a visible permutation. A design that mirrors lanes for a single byte in big-endian mode would move a byte at address 1 onto lane 2. A design that mirrors the whole word instead of the item would place a big-endian halfword at address 2 on lanes 0 and 1. The sign-extension cases use items whose top bit is set and items whose top bit is clear, which catches an extension taken from the wrong bit. The misaligned cases check both halfword and word offsets and the reserved size code, which exposes a design that still fires banks or leaks data.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int SIZE_W = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES),
    localparam int NB_W  = OFF_W + 1
) (
    input  logic [SIZE_W-1:0] size_code,
    input  logic [OFF_W-1:0]  addr_lo,
    output logic [LANES-1:0]  lane_en,
    output logic              off_bound,
    output logic [NB_W-1:0]   item_bytes
);

    int nb_int;

    always_comb begin
        nb_int    = 1;
        off_bound = 1'b1;
        if (int'(size_code) <= OFF_W) begin
            nb_int    = 1 << int'(size_code);
            off_bound = (int'(addr_lo) % nb_int) != 0;
        end
        item_bytes = NB_W'(nb_int);
        for (int k = 0; k < LANES; k++) begin
            lane_en[k] = !off_bound && (k >= int'(addr_lo))
                         && (k < int'(addr_lo) + nb_int);
        end
    end

    // R3: a suppressed access fires no bank
    always_comb begin
        a_r3_no_enable_when_off: assert (!off_bound || lane_en == '0)
            else $error("bank enabled on misaligned access");
    end

    // R1: a byte transfer lights exactly one bank
    always_comb begin
        a_r1_byte_onehot: assert (size_code != SZ_BYTE || $countones(lane_en) == 1)
            else $error("byte transfer not one-hot");
    end

    // R2: number of enabled banks equals the item size
    always_comb begin
        a_r2_count_matches: assert (off_bound || $countones(lane_en) == int'(item_bytes))
            else $error("enable count differs from item size");
    end

endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int NB_W   = OFF_W + 1,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              big_endian,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [NB_W-1:0]   item_bytes,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] mem_wdata
);

    int src;

    always_comb begin
        mem_wdata = '0;
        src       = 0;
        for (int k = 0; k < LANES; k++) begin
            if (big_endian) src = int'(addr_lo) + int'(item_bytes) - 1 - k;
            else            src = k - int'(addr_lo);
            if (lane_en[k] && src >= 0 && src < LANES)
                mem_wdata[k*LANE_W +: LANE_W] = core_wdata[src*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/lane_rd_align.sv
module lane_rd_align #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int NB_W   = OFF_W + 1,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              big_endian,
    input  logic              sign_ext,
    input  logic              off_bound,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [NB_W-1:0]   item_bytes,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] core_rdata
);

    int   lane;
    logic fill;

    always_comb begin
        core_rdata = '0;
        lane       = 0;
        fill       = 1'b0;
        if (!off_bound) begin
            for (int j = 0; j < LANES; j++) begin
                if (j < int'(item_bytes)) begin
                    if (big_endian) lane = int'(addr_lo) + int'(item_bytes) - 1 - j;
                    else            lane = int'(addr_lo) + j;
                    if (lane >= 0 && lane < LANES)
                        core_rdata[j*LANE_W +: LANE_W] = mem_rdata[lane*LANE_W +: LANE_W];
                    if (j == int'(item_bytes) - 1)
                        fill = sign_ext && core_rdata[j*LANE_W + LANE_W - 1];
                end else begin
                    core_rdata[j*LANE_W +: LANE_W] = {LANE_W{fill}};
                end
            end
        end
    end

    // R9: with sign extension the top byte copies the sign of the item
    always_comb begin
        a_r9_top_byte_fill: assert (off_bound || !sign_ext || int'(item_bytes) >= LANES
                || core_rdata[DATA_W-1:DATA_W-LANE_W] == {LANE_W{core_rdata[int'(item_bytes)*LANE_W-1]}})
            else $error("sign fill mismatch");
    end

endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int NB_W   = OFF_W + 1,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              big_endian,
    input  logic [SIZE_W-1:0] xfer_size,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic              sign_ext,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  bank_en,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              misaligned
);

    logic [NB_W-1:0] item_bytes;

    lane_decode #(.LANES(LANES)) u_decode (
        .size_code  (xfer_size),
        .addr_lo    (addr_lo),
        .lane_en    (bank_en),
        .off_bound  (misaligned),
        .item_bytes (item_bytes)
    );

    lane_wr_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .big_endian (big_endian),
        .addr_lo    (addr_lo),
        .item_bytes (item_bytes),
        .lane_en    (bank_en),
        .core_wdata (core_wdata),
        .mem_wdata  (mem_wdata)
    );

    lane_rd_align #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .big_endian (big_endian),
        .sign_ext   (sign_ext),
        .off_bound  (misaligned),
        .addr_lo    (addr_lo),
        .item_bytes (item_bytes),
        .mem_rdata  (mem_rdata),
        .core_rdata (core_rdata)
    );

    // R10: lanes of disabled banks stay quiet
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
            always_comb begin
                a_r10_idle_lane_zero: assert (bank_en[k] || mem_wdata[k*LANE_W +: LANE_W] == '0)
                    else $error("data on disabled lane");
            end
        end
    endgenerate

    // R11: a misaligned access returns nothing to the core
    always_comb begin
        a_r11_no_read_when_off: assert (!misaligned || core_rdata == '0)
            else $error("read data on misaligned access");
    end

endmodule

// File: tb/lane_steer_bench.sv
module lane_steer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        big_endian = 1'b0;
    logic [1:0]  xfer_size  = 2'd0;
    logic [1:0]  addr_lo    = 2'd0;
    logic        sign_ext   = 1'b0;
    logic [31:0] core_wdata = 32'h0;
    logic [31:0] mem_rdata  = 32'h0;
    logic [3:0]  bank_en;
    logic [31:0] mem_wdata;
    logic [31:0] core_rdata;
    logic        misaligned;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] WV = 32'hA1B2C3D4;
    localparam logic [31:0] RV = 32'hF08E7D1C;

    always #5 clk = ~clk;

    lane_steer u_lane_steer (
        .big_endian (big_endian),
        .xfer_size  (xfer_size),
        .addr_lo    (addr_lo),
        .sign_ext   (sign_ext),
        .core_wdata (core_wdata),
        .mem_rdata  (mem_rdata),
        .bank_en    (bank_en),
        .mem_wdata  (mem_wdata),
        .core_rdata (core_rdata),
        .misaligned (misaligned)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic be, input logic [1:0] sz, input logic [1:0] a, input logic sx);
        @(negedge clk);
        big_endian = be; xfer_size = sz; addr_lo = a; sign_ext = sx;
        core_wdata = WV; mem_rdata = RV;
        @(posedge clk);
        #2;
    endtask

    task automatic t_idle();
        apply(0, 2'd0, 2'd0, 0);
        check("R1 idle enables", {28'd0, bank_en}, 32'h1);
        check("R3 idle flag", {31'd0, misaligned}, 32'h0);
    endtask

    task automatic t_bytes();
        apply(0, 2'd0, 2'd2, 0);
        check("R1 LE byte en", {28'd0, bank_en}, 32'h4);
        check("R4 R10 LE byte wdata", mem_wdata, 32'h00D40000);
        check("R6 R8 LE byte zext", core_rdata, 32'h0000008E);
        apply(0, 2'd0, 2'd2, 1);
        check("R9 LE byte sext neg", core_rdata, 32'hFFFFFF8E);
        apply(0, 2'd0, 2'd0, 1);
        check("R9 LE byte sext pos", core_rdata, 32'h0000001C);
        apply(1, 2'd0, 2'd1, 0);
        check("R1 BE byte en", {28'd0, bank_en}, 32'h2);
        check("R5 R10 BE byte wdata", mem_wdata, 32'h0000D400);
        check("R7 BE byte read", core_rdata, 32'h0000007D);
        apply(1, 2'd0, 2'd3, 1);
        check("R9 BE byte sext", core_rdata, 32'hFFFFFFF0);
    endtask

    task automatic t_halves();
        apply(0, 2'd1, 2'd2, 0);
        check("R2 LE half en", {28'd0, bank_en}, 32'hC);
        check("R4 LE half wdata", mem_wdata, 32'hC3D40000);
        check("R6 R8 LE half zext", core_rdata, 32'h0000F08E);
        apply(0, 2'd1, 2'd2, 1);
        check("R9 LE half sext", core_rdata, 32'hFFFFF08E);
        apply(0, 2'd1, 2'd0, 1);
        check("R2 LE half en low", {28'd0, bank_en}, 32'h3);
        check("R4 LE half wdata low", mem_wdata, 32'h0000C3D4);
        check("R9 LE half sext pos", core_rdata, 32'h00007D1C);
        apply(1, 2'd1, 2'd2, 1);
        check("R5 BE half wdata", mem_wdata, 32'hD4C30000);
        check("R7 R9 BE half sext", core_rdata, 32'hFFFF8EF0);
        apply(1, 2'd1, 2'd0, 0);
        check("R5 BE half wdata low", mem_wdata, 32'h0000D4C3);
        check("R7 BE half read low", core_rdata, 32'h00001C7D);
    endtask

    task automatic t_words();
        apply(0, 2'd2, 2'd0, 1);
        check("R2 word en", {28'd0, bank_en}, 32'hF);
        check("R4 LE word wdata", mem_wdata, WV);
        check("R6 R9 LE word read", core_rdata, RV);
        apply(1, 2'd2, 2'd0, 1);
        check("R5 BE word wdata", mem_wdata, 32'hD4C3B2A1);
        check("R7 R9 BE word read", core_rdata, 32'h1C7D8EF0);
    endtask

    task automatic t_misaligned();
        apply(0, 2'd1, 2'd1, 1);
        check("R3 half odd flag", {31'd0, misaligned}, 32'h1);
        check("R3 half odd en", {28'd0, bank_en}, 32'h0);
        check("R11 half odd wdata", mem_wdata, 32'h0);
        check("R11 half odd rdata", core_rdata, 32'h0);
        apply(1, 2'd2, 2'd2, 0);
        check("R3 word off flag", {31'd0, misaligned}, 32'h1);
        check("R3 word off en", {28'd0, bank_en}, 32'h0);
        check("R11 word off rdata", core_rdata, 32'h0);
        apply(0, 2'd3, 2'd0, 0);
        check("R3 reserved flag", {31'd0, misaligned}, 32'h1);
        check("R11 reserved wdata", mem_wdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_bytes();
        t_halves();
        t_words();
        t_misaligned();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule